// File: doc/BRIEF.md
# Prescaled PWM Timer with Staged Update

This block generates one pulse-width-modulated output from a small 32-bit register bus. The input clock passes through a power-of-two prescaler. Each prescaled tick advances a period counter of `CNT_W` bits. In each period the output is high for a programmed number of ticks and low for the remaining ticks. Two registers hold the whole setup. The control word carries the enable, a hold flag and the prescale exponent. The count word carries the period length and the high-time.

The running timer never uses the bus registers directly. It uses an active set of period, high-time and exponent. That set is refreshed from the registers whenever the channel is idle, and at each period boundary while the hold flag is clear. Software sets the hold flag, writes the new period, high-time and exponent in any order, and then clears the flag. All three values then take effect together at the start of a period, so no period is ever produced from a mix of old and new values. Exponents above 24 are treated as 24.

Top module: `pwm_staged_timer`

## Requirements
- R1: After reset both registers read 0 and `pwm_out` is low. A write to address 0x0 (control) or 0x4 (count) stores all 32 bits, and a later read returns them. A read of any other address returns 0. Read data appears one cycle after the address is presented.
- R2: The prescale exponent d is control bits 19:16 as d>>1, with control bit 15 as the least significant bit of d. One counting tick lasts 2^d input clock cycles.
- R3: The period P is count bits 25:16 and the high-time D is count bits 9:0. While running, `pwm_out` is high for the first D ticks of each P-tick period and low for the rest. With sample k counted from the edge that captures the enabling write (k=0), the output at sample k is 0 for k=0 and ((k-1)>>d) mod P < D for k ≥ 1.
- R4: A high-time equal to or larger than the period gives a constant high output while enabled.
- R5: If the active period or high-time is 0, `pwm_out` stays low even with the enable bit (control bit 0) set.
- R6: From the edge after a write clears control bit 0, `pwm_out` is low. A later enable restarts counting from the start of a period, with the same timing as R3.
- R7: While the hold bit (control bit 11) is set, writes to the period, high-time and exponent do not change the running waveform. Once the hold bit is clear, the stored values take effect together at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the prescaler input |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the addressed register |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Clearing the hold bit can be captured on the same edge at which the period counter wraps. The hold value sampled on that edge is then still set, so the staged values wait for the following boundary. The bench provokes this by releasing the hold two cycles after the single-tick high pulse of a 4-tick period, which lands the release on the wrap edge. It does not try to predict which boundary performs the load. Instead it measures two full periods after the release and requires the second one to show the new high-time, period and exponent together (6 high of 12 cycles). A period that mixes old and new values fails this check.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_CNT  = 4;
  // control word layout
  localparam int EN_BIT      = 0;
  localparam int HOLD_BIT    = 11;
  localparam int DIV_LSB_BIT = 15;
  localparam int DIV_HI_LSB  = 16;
  localparam int DIV_HI_W    = 4;
  localparam int DIV_MAX     = 24;
  // count word layout
  localparam int PER_LSB  = 16;
  localparam int DUTY_LSB = 0;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cnt_q
);
  logic sel_ctrl;
  logic sel_cnt;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_cnt  = (bus_addr == ADDR_W'(OFS_CNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cnt_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata;
      if (bus_wr && sel_cnt)  cnt_q  <= bus_wdata;
      if (sel_ctrl)      bus_rdata <= ctrl_q;
      else if (sel_cnt)  bus_rdata <= cnt_q;
      else               bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/pwm_timer_stage.sv
module pwm_timer_stage #(
  parameter int CNT_W   = 10,
  parameter int DIV_W   = 5,
  parameter int DIV_LIM = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_ok,
  input  logic             hold,
  input  logic [CNT_W-1:0] per_raw,
  input  logic [CNT_W-1:0] duty_raw,
  input  logic [DIV_W-1:0] div_raw,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_duty,
  output logic [DIV_W-1:0] act_div
);
  logic [DIV_W-1:0] div_lim;

  always_comb begin
    if (div_raw > DIV_W'(DIV_LIM)) div_lim = DIV_W'(DIV_LIM);
    else                           div_lim = div_raw;
  end

  // the active set moves only on an idle cycle or a period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      act_period <= '0;
      act_duty   <= '0;
      act_div    <= '0;
    end else if (load_ok && !hold) begin
      act_period <= per_raw;
      act_duty   <= duty_raw;
      act_div    <= div_lim;
    end
  end
endmodule

// File: rtl/pwm_timer_prescale.sv
module pwm_timer_prescale #(
  parameter int DIV_W = 5,
  parameter int PRE_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] wrap_at;

  // 2^div - 1; with div == PRE_W the shift gives 0 and the subtract all ones
  assign wrap_at = (PRE_W'(1) << div) - PRE_W'(1);
  assign tick    = run && (pre_q == wrap_at);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] act_period,
  input  logic [CNT_W-1:0] act_duty,
  output logic             run,
  output logic             boundary,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pwm_out
);
  logic last;

  assign run      = en && (act_period != '0) && (act_duty != '0);
  assign last     = (cnt_q == act_period - CNT_W'(1));
  assign boundary = !run || (tick && last);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= run && (cnt_q < act_duty);
  end
endmodule

// File: rtl/pwm_staged_timer.sv
module pwm_staged_timer
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 10,
  parameter int PRE_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam int DIV_W = DIV_HI_W + 1;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cnt_word;
  logic              ctrl_en;
  logic              ctrl_hold;
  logic [DIV_W-1:0]  div_raw;
  logic [CNT_W-1:0]  per_raw;
  logic [CNT_W-1:0]  duty_raw;
  logic [CNT_W-1:0]  act_period;
  logic [CNT_W-1:0]  act_duty;
  logic [DIV_W-1:0]  act_div;
  logic              run;
  logic              tick;
  logic              boundary;
  logic [CNT_W-1:0]  cnt_q;

  pwm_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl_q(ctrl_q), .cnt_q(cnt_word)
  );

  assign ctrl_en   = ctrl_q[EN_BIT];
  assign ctrl_hold = ctrl_q[HOLD_BIT];
  assign div_raw   = {ctrl_q[DIV_HI_LSB +: DIV_HI_W], ctrl_q[DIV_LSB_BIT]};
  assign per_raw   = cnt_word[PER_LSB +: CNT_W];
  assign duty_raw  = cnt_word[DUTY_LSB +: CNT_W];

  pwm_timer_stage #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_LIM(DIV_MAX)) u_stage (
    .clk(clk), .rst(rst), .load_ok(boundary), .hold(ctrl_hold),
    .per_raw(per_raw), .duty_raw(duty_raw), .div_raw(div_raw),
    .act_period(act_period), .act_duty(act_duty), .act_div(act_div)
  );

  pwm_timer_prescale #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .div(act_div), .tick(tick)
  );

  pwm_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(ctrl_en), .tick(tick),
    .act_period(act_period), .act_duty(act_duty),
    .run(run), .boundary(boundary), .cnt_q(cnt_q), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             hold,
  input logic             run,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_period,
  input logic [CNT_W-1:0] act_duty,
  input logic [DIV_W-1:0] act_div,
  input logic             pwm_out
);
  // R6: a cleared enable forces the output low one edge later
  assert_off_low_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);

  // R5: a zero active count keeps the output low
  assert_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
    (act_period == '0 || act_duty == '0) |=> !pwm_out);

  // R3: the period counter stays inside the active period
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < act_period));

  // R7: while held, the active set does not move
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(act_period) && $stable(act_duty) && $stable(act_div)));

  // R2: with a nonzero exponent ticks are never back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && act_div != '0) |=> (!tick || act_div == '0));
endmodule

bind pwm_staged_timer pwm_timer_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .en(ctrl_en), .hold(ctrl_hold), .run(run),
  .tick(tick), .cnt(cnt_q), .act_period(act_period), .act_duty(act_duty),
  .act_div(act_div), .pwm_out(pwm_out)
);

// File: tb/pwm_staged_timer_test.sv
module pwm_staged_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         pwm_out;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 1'b0;
  int    exp_q[$];
  string sb_tag = "";

  pwm_staged_timer uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one expected output bit per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      e = exp_q.pop_front();
      chk(pwm_out == e[0], sb_tag, pwm_out, e);
    end
  end

  function automatic logic [31:0] ctrl_word(input int d, input bit hold, input bit en);
    return (32'((d >> 1) & 15) << 16) | (32'(d & 1) << 15) | (32'(hold) << 11) | 32'(en);
  endfunction

  function automatic logic [31:0] cnt_word(input int p, input int dt);
    return (32'(p & 1023) << 16) | 32'(dt & 1023);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // driver: program, enable, and push the expected waveform
  task automatic run_pattern(input int p, input int dt, input int d, input int n, input string tag);
    wr(4'h0, ctrl_word(d, 1'b0, 1'b0));
    wr(4'h4, cnt_word(p, dt));
    @(negedge clk);
    bus_addr = 4'h0; bus_wdata = ctrl_word(d, 1'b0, 1'b1); bus_wr = 1'b1;
    @(posedge clk);
    #1;
    sb_tag = tag;
    exp_q.push_back(0);
    for (int k = 1; k < n; k++) begin
      if (p == 0 || dt == 0) exp_q.push_back(0);
      else exp_q.push_back(((((k - 1) >> d) % p) < dt) ? 1 : 0);
    end
    @(negedge clk);
    bus_wr = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int per);
    int lo;
    while (pwm_out !== 1'b0) @(negedge clk);
    while (pwm_out !== 1'b1) @(negedge clk);
    hi = 0; lo = 0;
    while (pwm_out === 1'b1) begin hi++; @(negedge clk); end
    while (pwm_out === 1'b0) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  initial begin
    logic [31:0] v;
    int h, pr;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state and readback
    chk(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);
    rd(4'h0, v); chk(v == 32'h0, "R1 reset ctrl", v, 0);
    rd(4'h4, v); chk(v == 32'h0, "R1 reset count", v, 0);
    wr(4'h0, 32'h5A0F_8C00);
    rd(4'h0, v); chk(v == 32'h5A0F_8C00, "R1 ctrl readback", v, 32'h5A0F_8C00);
    wr(4'h4, 32'hFC3F_0155);
    rd(4'h4, v); chk(v == 32'hFC3F_0155, "R1 count readback", v, 32'hFC3F_0155);
    rd(4'h8, v); chk(v == 32'h0, "R1 unmapped read", v, 0);
    chk(pwm_out == 1'b0, "R1 output while disabled", pwm_out, 0);

    // R3 basic waveform, R2 exponent encodings
    run_pattern(5, 2, 0, 40, "R3 P5 D2 d0");
    run_pattern(4, 1, 3, 80, "R2 odd exponent d3");
    run_pattern(3, 2, 2, 60, "R2 even exponent d2");
    // R4 high-time at or above period
    run_pattern(4, 7, 0, 30, "R4 D7 over P4");
    run_pattern(6, 6, 1, 30, "R4 D equals P");
    // R5 zero counts
    run_pattern(0, 3, 0, 25, "R5 zero period");
    run_pattern(6, 0, 0, 25, "R5 zero high-time");

    // R6 disable mid-run, then restart
    run_pattern(8, 6, 0, 12, "R3 P8 D6");
    wr(4'h0, ctrl_word(0, 1'b0, 1'b0));
    repeat (15) begin
      @(negedge clk);
      chk(pwm_out == 1'b0, "R6 low after disable", pwm_out, 0);
    end
    run_pattern(8, 6, 0, 30, "R6 restart from period start");

    // R7 staged update under hold
    run_pattern(4, 1, 0, 8, "R3 P4 D1");
    wr(4'h0, ctrl_word(0, 1'b1, 1'b1));
    wr(4'h4, cnt_word(6, 3));
    wr(4'h0, ctrl_word(1, 1'b1, 1'b1));
    measure(h, pr);
    chk(h == 1, "R7 held high-time", h, 1);
    chk(pr == 4, "R7 held period", pr, 4);
    rd(4'h4, v); chk(v == cnt_word(6, 3), "R1 staged count readback", v, cnt_word(6, 3));
    measure(h, pr);
    @(negedge clk);
    wr(4'h0, ctrl_word(1, 1'b0, 1'b1));
    measure(h, pr);
    measure(h, pr);
    chk(h == 6, "R7 released high-time", h, 6);
    chk(pr == 12, "R7 released period", pr, 12);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule